// File: doc/BRIEF.md
# Quad Wiper and Data Register Bank Controller

This block holds the register state behind four digitally controlled potentiometer channels. Every channel owns one volatile 6-bit wiper counter, which sets the active tap of its resistor string, and four 6-bit data registers that stand in for nonvolatile storage cells. A serial front end decodes host commands and presents them here as single-cycle requests. Each request carries an opcode, a channel index, a register index, a data byte and an up/down flag. A separate pulse, `cmd_end`, marks the end of a command frame, which is the point where the chip select is released.

Wiper loads, increment/decrement steps and reads take effect on the clock edge that samples the request. Any change to a data register is first staged. The change is committed only at the end-of-frame pulse, and the commit starts a busy interval that models the store time of the nonvolatile cells. A write-protect input gates every data-register change. On reset each data register takes a fixed initial value, which models the stored contents, and each wiper is recalled from its channel's register 0. Every wiper code is also decoded into a one-hot 64-tap select vector.

Top module: `potbank_ctrl`

## Requirements
- R1: While `rst_n` is low, and after it is released, data register `r` of channel `c` holds `(13*c + 7*r + 5) mod 64`. Each wiper equals its channel's register 0, and `wip` is low.
- R2: For each channel `c`, `tap_sel[c*64 +: 64]` has exactly one bit set, at index equal to that channel's wiper code. Code 00h selects bit 0, the low end, and 3Fh selects bit 63, the high end.
- R3: Opcode Ah (write wiper) sets the chosen channel's wiper to `req_data[5:0]` on the sampling edge. Opcode 9h (read wiper) raises `rd_valid` for one cycle after the sampling edge, with `rd_data` equal to that wiper.
- R4: Opcode Bh (read data register) returns the committed value of register `req_reg` of channel `req_ch` on `rd_data`, with the same one-cycle timing as R3.
- R5: Opcode Dh copies register `req_reg` of channel `req_ch` into that channel's wiper on the sampling edge. Opcode Eh stages a copy of that wiper into that register.
- R6: Opcode 1h loads every channel's wiper from that channel's register `req_reg` at once. Opcode 8h stages a copy of every wiper into register `req_reg` of its own channel.
- R7: Opcode Ch stages `req_data` for register `req_reg` of channel `req_ch`. A staged change is committed at the first `cmd_end` pulse after it, and not before. `wip` rises on that edge and stays high for exactly `STORE_CYCLES` clock cycles.
- R8: While `wp_n` is low, requests with opcode Ch, Eh or 8h are discarded and leave every data register unchanged. Wiper writes are still carried out.
- R9: While `wip` is high, or while a change is already staged, further requests with opcode Ch, Eh or 8h are discarded. Wiper writes, wiper reads and status reads are still served.
- R10: Opcode 2h moves only the chosen channel's wiper, by exactly one code: up when `step_up` is 1, down when it is 0.
- R11: A step up from 3Fh leaves the wiper at 3Fh, and a step down from 00h leaves it at 00h. The counter never wraps.
- R12: Opcode 5h (status read) returns `wip` in `rd_data[0]` with all other bits zero, timed as in R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous power-up reset; triggers register-0 recall |
| req_valid | input | 1 | A decoded request is present this cycle |
| req_op | input | 4 | Request opcode |
| req_ch | input | 2 | Channel index |
| req_reg | input | 2 | Data register index |
| req_data | input | 6 | Data for wiper or data register writes |
| step_up | input | 1 | Direction of a step request (1 = towards high end) |
| cmd_end | input | 1 | End-of-frame pulse; commits a staged nonvolatile change |
| wp_n | input | 1 | Active-low write protect for data registers |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 6 | Read result |
| wip | output | 1 | Nonvolatile store in progress |
| wiper_code | output | 24 | Four 6-bit wiper codes, channel 0 in the low bits |
| tap_sel | output | 256 | Four one-hot 64-bit tap selects, channel 0 in the low bits |

## Verification
Wiper changes, register commits, the rise of `wip` and read results all appear one clock after the edge that samples the request or the `cmd_end` pulse. `wip` falls `STORE_CYCLES` cycles after it rises. The tap select follows the wiper code with no extra register. The bench drives each stimulus on a falling edge and advances a behavioural model for that one rising edge. On the next falling edge it compares every output with the model, so each expected value is taken in the exact cycle in which it becomes due. A shortened `STORE_CYCLES` keeps the busy window short, and the window is checked cycle by cycle up to its final cycle.

// File: rtl/potbank_pkg.sv
package potbank_pkg;

  typedef enum logic [3:0] {
    OP_GXFR_D2W = 4'h1,
    OP_STEP     = 4'h2,
    OP_STATUS   = 4'h5,
    OP_GXFR_W2D = 4'h8,
    OP_RD_WCR   = 4'h9,
    OP_WR_WCR   = 4'hA,
    OP_RD_DR    = 4'hB,
    OP_WR_DR    = 4'hC,
    OP_XFR_D2W  = 4'hD,
    OP_XFR_W2D  = 4'hE
  } pot_op_e;

  // Initial stored contents of a data register at power-up.
  function automatic int init_code(int ch, int idx, int wbits);
    return (ch * 13 + idx * 7 + 5) % (1 << wbits);
  endfunction

  // One-code wiper step that stops at both ends.
  function automatic int sat_step(int v, bit up, int wbits);
    int top;
    top = (1 << wbits) - 1;
    if (up) return (v >= top) ? top : v + 1;
    else    return (v <= 0) ? 0 : v - 1;
  endfunction

endpackage

// File: rtl/potbank_channel.sv
module potbank_channel
  import potbank_pkg::*;
#(
  parameter int WBITS  = 6,
  parameter int NUM_DR = 4,
  parameter int CH_IDX = 0,
  localparam int SEL_BITS = $clog2(NUM_DR)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wcr_ld,
  input  logic [WBITS-1:0]        wcr_val,
  input  logic                    step_en,
  input  logic                    step_up,
  input  logic                    dr_we,
  input  logic [SEL_BITS-1:0]     dr_sel,
  input  logic [WBITS-1:0]        dr_val,
  output logic [WBITS-1:0]        wcr_q,
  output logic [NUM_DR*WBITS-1:0] dr_flat
);

  logic [WBITS-1:0] dr_mem [NUM_DR];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_DR; i++)
        dr_mem[i] <= WBITS'(init_code(CH_IDX, i, WBITS));
      wcr_q <= WBITS'(init_code(CH_IDX, 0, WBITS));
    end else begin
      if (dr_we) dr_mem[dr_sel] <= dr_val;
      if (wcr_ld)
        wcr_q <= wcr_val;
      else if (step_en)
        wcr_q <= WBITS'(sat_step(int'(wcr_q), step_up, WBITS));
    end
  end

  for (genvar i = 0; i < NUM_DR; i++) begin : g_flat
    assign dr_flat[i*WBITS +: WBITS] = dr_mem[i];
  end

  localparam logic [WBITS-1:0] CODE_MAX = '1;

  AST_STEP_SAT_HI: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !wcr_ld && step_up && wcr_q == CODE_MAX) |=> wcr_q == CODE_MAX); // R11
  AST_STEP_SAT_LO: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !wcr_ld && !step_up && wcr_q == '0) |=> wcr_q == '0); // R11
  AST_STEP_UNIT: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !wcr_ld) |=> ((int'(wcr_q) - int'($past(wcr_q)) <= 1) &&
                              (int'($past(wcr_q)) - int'(wcr_q) <= 1))); // R10
  AST_WCR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!wcr_ld && !step_en) |=> $stable(wcr_q)); // R10
  AST_DR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !dr_we |=> $stable(dr_flat)); // R7

endmodule

// File: rtl/potbank_nvstage.sv
module potbank_nvstage #(
  parameter int NUM_CH       = 4,
  parameter int WBITS        = 6,
  parameter int NUM_DR       = 4,
  parameter int STORE_CYCLES = 2000000,
  localparam int SEL_BITS = $clog2(NUM_DR),
  localparam int CNT_W    = $clog2(STORE_CYCLES + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    nv_req,
  input  logic                    wp_n,
  input  logic                    cmd_end,
  input  logic [NUM_CH-1:0]       stage_mask,
  input  logic [SEL_BITS-1:0]     stage_reg,
  input  logic [NUM_CH*WBITS-1:0] stage_vals,
  output logic                    commit_fire,
  output logic [NUM_CH-1:0]       pend_mask,
  output logic [SEL_BITS-1:0]     pend_reg,
  output logic [NUM_CH*WBITS-1:0] pend_vals,
  output logic                    wip
);

  logic             pend_valid;
  logic             accept;
  logic [CNT_W-1:0] cnt;

  assign accept      = nv_req && wp_n && !wip && !pend_valid;
  assign commit_fire = cmd_end && pend_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_valid <= 1'b0;
      pend_mask  <= '0;
      pend_reg   <= '0;
      pend_vals  <= '0;
    end else if (commit_fire) begin
      pend_valid <= 1'b0;
    end else if (accept) begin
      pend_valid <= 1'b1;
      pend_mask  <= stage_mask;
      pend_reg   <= stage_reg;
      pend_vals  <= stage_vals;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wip <= 1'b0;
      cnt <= '0;
    end else if (commit_fire) begin
      wip <= 1'b1;
      cnt <= CNT_W'(STORE_CYCLES - 1);
    end else if (wip) begin
      if (cnt == '0) wip <= 1'b0;
      else           cnt <= cnt - 1'b1;
    end
  end

  AST_WP_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (nv_req && !wp_n && !pend_valid) |=> !pend_valid); // R8
  AST_NO_COMMIT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    wip |-> !commit_fire); // R9
  AST_WIP_AFTER_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    commit_fire |=> wip); // R7
  AST_WIP_ONLY_FROM_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wip) |-> $past(commit_fire)); // R7

endmodule

// File: rtl/potbank_tapdec.sv
module potbank_tapdec #(
  parameter int WBITS = 6,
  localparam int TAPS = 1 << WBITS
) (
  input  logic [WBITS-1:0] code,
  output logic [TAPS-1:0]  sel
);

  always_comb begin
    sel = '0;
    sel[code] = 1'b1;
  end

endmodule

// File: rtl/potbank_ctrl.sv
module potbank_ctrl
  import potbank_pkg::*;
#(
  parameter int NUM_CH       = 4,
  parameter int WBITS        = 6,
  parameter int NUM_DR       = 4,
  parameter int STORE_CYCLES = 2000000,
  localparam int CH_BITS  = $clog2(NUM_CH),
  localparam int SEL_BITS = $clog2(NUM_DR),
  localparam int TAPS     = 1 << WBITS
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic [3:0]             req_op,
  input  logic [CH_BITS-1:0]     req_ch,
  input  logic [SEL_BITS-1:0]    req_reg,
  input  logic [WBITS-1:0]       req_data,
  input  logic                   step_up,
  input  logic                   cmd_end,
  input  logic                   wp_n,
  output logic                   rd_valid,
  output logic [WBITS-1:0]       rd_data,
  output logic                   wip,
  output logic [NUM_CH*WBITS-1:0] wiper_code,
  output logic [NUM_CH*TAPS-1:0]  tap_sel
);

  pot_op_e op;
  assign op = pot_op_e'(req_op);

  logic [WBITS-1:0]        wcr     [NUM_CH];
  logic [NUM_DR*WBITS-1:0] dr_flat [NUM_CH];

  logic                    nv_req;
  logic [NUM_CH-1:0]       stage_mask;
  logic [NUM_CH*WBITS-1:0] stage_vals;
  logic                    commit_fire;
  logic [NUM_CH-1:0]       pend_mask;
  logic [SEL_BITS-1:0]     pend_reg;
  logic [NUM_CH*WBITS-1:0] pend_vals;

  assign nv_req = req_valid &&
                  (op == OP_WR_DR || op == OP_XFR_W2D || op == OP_GXFR_W2D);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic             sel_me;
    logic             ld;
    logic [WBITS-1:0] ld_val;
    logic             st;

    assign sel_me = (req_ch == CH_BITS'(c));
    assign ld = req_valid &&
                (((op == OP_WR_WCR || op == OP_XFR_D2W) && sel_me) ||
                 op == OP_GXFR_D2W);
    assign ld_val = (op == OP_WR_WCR) ? req_data
                                      : dr_flat[c][int'(req_reg)*WBITS +: WBITS];
    assign st = req_valid && (op == OP_STEP) && sel_me;

    potbank_channel #(
      .WBITS (WBITS),
      .NUM_DR(NUM_DR),
      .CH_IDX(c)
    ) u_chan (
      .clk    (clk),
      .rst_n  (rst_n),
      .wcr_ld (ld),
      .wcr_val(ld_val),
      .step_en(st),
      .step_up(step_up),
      .dr_we  (commit_fire && pend_mask[c]),
      .dr_sel (pend_reg),
      .dr_val (pend_vals[c*WBITS +: WBITS]),
      .wcr_q  (wcr[c]),
      .dr_flat(dr_flat[c])
    );

    assign stage_mask[c] = (op == OP_GXFR_W2D) || sel_me;
    assign stage_vals[c*WBITS +: WBITS] = (op == OP_WR_DR) ? req_data : wcr[c];
    assign wiper_code[c*WBITS +: WBITS] = wcr[c];

    potbank_tapdec #(.WBITS(WBITS)) u_tap (
      .code(wcr[c]),
      .sel (tap_sel[c*TAPS +: TAPS])
    );

    AST_TAP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot(tap_sel[c*TAPS +: TAPS])); // R2
  end

  potbank_nvstage #(
    .NUM_CH      (NUM_CH),
    .WBITS       (WBITS),
    .NUM_DR      (NUM_DR),
    .STORE_CYCLES(STORE_CYCLES)
  ) u_nv (
    .clk        (clk),
    .rst_n      (rst_n),
    .nv_req     (nv_req),
    .wp_n       (wp_n),
    .cmd_end    (cmd_end),
    .stage_mask (stage_mask),
    .stage_reg  (req_reg),
    .stage_vals (stage_vals),
    .commit_fire(commit_fire),
    .pend_mask  (pend_mask),
    .pend_reg   (pend_reg),
    .pend_vals  (pend_vals),
    .wip        (wip)
  );

  logic             rd_hit;
  logic [WBITS-1:0] rd_next;

  always_comb begin
    rd_hit  = 1'b1;
    rd_next = '0;
    case (op)
      OP_RD_WCR: rd_next = wcr[req_ch];
      OP_RD_DR:  rd_next = dr_flat[req_ch][int'(req_reg)*WBITS +: WBITS];
      OP_STATUS: rd_next = WBITS'(wip);
      default:   rd_hit  = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= req_valid && rd_hit;
      if (req_valid && rd_hit) rd_data <= rd_next;
    end
  end

  AST_STATUS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && op == OP_STATUS) |=> (rd_valid && rd_data == WBITS'($past(wip)))); // R12
  AST_READ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && op == OP_RD_WCR) |=> rd_valid); // R3

endmodule

// File: tb/potbank_ctrl_tb.sv
module potbank_ctrl_tb;

  localparam int S = 20;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic [3:0]   req_op = '0;
  logic [1:0]   req_ch = '0;
  logic [1:0]   req_reg = '0;
  logic [5:0]   req_data = '0;
  logic         step_up = 1'b0;
  logic         cmd_end = 1'b0;
  logic         wp_n = 1'b1;
  logic         rd_valid;
  logic [5:0]   rd_data;
  logic         wip;
  logic [23:0]  wiper_code;
  logic [255:0] tap_sel;

  always #2.5 clk = ~clk;

  potbank_ctrl #(.STORE_CYCLES(S)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_ch(req_ch), .req_reg(req_reg), .req_data(req_data), .step_up(step_up),
    .cmd_end(cmd_end), .wp_n(wp_n), .rd_valid(rd_valid), .rd_data(rd_data),
    .wip(wip), .wiper_code(wiper_code), .tap_sel(tap_sel)
  );

  int checks = 0;
  int errors = 0;

  // reference model state
  int m_wcr [4];
  int m_dr  [4][4];
  bit m_pend;
  bit m_pmask [4];
  int m_pval [4];
  int m_preg;
  bit m_wip;
  int m_cnt;
  bit e_rdv;
  int e_rdd;

  task automatic model_reset();
    for (int c = 0; c < 4; c++) begin
      for (int r = 0; r < 4; r++) m_dr[c][r] = (13 * c + 7 * r + 5) % 64;
      m_wcr[c] = m_dr[c][0];
    end
    m_pend = 0; m_wip = 0; m_cnt = 0; e_rdv = 0; e_rdd = 0;
  endtask

  task automatic chk(string tag, string what, logic [255:0] act, logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic compare(string tag);
    logic [23:0]  ew;
    logic [255:0] et;
    ew = '0; et = '0;
    for (int c = 0; c < 4; c++) begin
      ew[c*6 +: 6] = 6'(m_wcr[c]);
      et[c*64 + m_wcr[c]] = 1'b1;
    end
    chk(tag, "wiper_code", 256'(wiper_code), 256'(ew));
    chk("R2", "tap_sel", tap_sel, et);
    chk(tag, "wip", 256'(wip), 256'(m_wip));
    chk(tag, "rd_valid", 256'(rd_valid), 256'(e_rdv));
    if (e_rdv) chk(tag, "rd_data", 256'(rd_data), 256'(e_rdd));
  endtask

  // One clock: drive at falling edge, model the rising edge, compare at next falling edge.
  task automatic cyc(string tag, bit v, int op, int ch, int rg, int d, bit up, bit ce);
    int  n_wcr [4];
    bit  commit, accept, nv;
    req_valid = v; req_op = 4'(op); req_ch = 2'(ch); req_reg = 2'(rg);
    req_data = 6'(d); step_up = up; cmd_end = ce;
    e_rdv = v && (op == 9 || op == 11 || op == 5);
    if (op == 9) e_rdd = m_wcr[ch];
    else if (op == 11) e_rdd = m_dr[ch][rg];
    else if (op == 5) e_rdd = m_wip;
    commit = ce && m_pend;
    nv = v && (op == 12 || op == 14 || op == 8);
    accept = nv && wp_n && !m_wip && !m_pend;
    for (int c = 0; c < 4; c++) n_wcr[c] = m_wcr[c];
    if (v) begin
      case (op)
        10: n_wcr[ch] = d;
        13: n_wcr[ch] = m_dr[ch][rg];
        1:  for (int c = 0; c < 4; c++) n_wcr[c] = m_dr[c][rg];
        2:  n_wcr[ch] = up ? ((m_wcr[ch] == 63) ? 63 : m_wcr[ch] + 1)
                           : ((m_wcr[ch] == 0) ? 0 : m_wcr[ch] - 1);
        default: ;
      endcase
    end
    if (commit) begin
      for (int c = 0; c < 4; c++) if (m_pmask[c]) m_dr[c][m_preg] = m_pval[c];
      m_pend = 0;
      m_wip = 1; m_cnt = S - 1;
    end else begin
      if (m_wip) begin
        if (m_cnt == 0) m_wip = 0; else m_cnt--;
      end
      if (accept) begin
        m_pend = 1; m_preg = rg;
        for (int c = 0; c < 4; c++) begin
          m_pmask[c] = (op == 8) || (c == ch);
          m_pval[c]  = (op == 12) ? d : m_wcr[c];
        end
      end
    end
    for (int c = 0; c < 4; c++) m_wcr[c] = n_wcr[c];
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic idle(string tag, int n);
    for (int i = 0; i < n; i++) cyc(tag, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    req_valid = 0; cmd_end = 0;
    model_reset();
    repeat (3) @(negedge clk);
    compare("R1");
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();

    // R4: read every data register after reset
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++) cyc("R4", 1, 11, c, r, 0, 0, 0);
    // R3: wiper read and write
    cyc("R3", 1, 9, 2, 0, 0, 0, 0);
    cyc("R3", 1, 10, 1, 0, 6'h2A, 0, 0);
    cyc("R3", 1, 9, 1, 0, 0, 0, 0);
    // R10: steps on channel 2
    repeat (3) cyc("R10", 1, 2, 2, 0, 0, 1, 0);
    cyc("R10", 1, 2, 2, 0, 0, 0, 0);
    // R11: saturation at both ends
    cyc("R11", 1, 10, 0, 0, 6'h3F, 0, 0);
    repeat (2) cyc("R11", 1, 2, 0, 0, 0, 1, 0);
    cyc("R11", 1, 10, 0, 0, 6'h00, 0, 0);
    repeat (2) cyc("R11", 1, 2, 0, 0, 0, 0, 0);
    cyc("R11", 1, 9, 0, 0, 0, 0, 0);
    // R5 / R6: register to wiper transfers
    cyc("R5", 1, 13, 3, 2, 0, 0, 0);
    cyc("R6", 1, 1, 0, 1, 0, 0, 0);
    // R7: staged data write, committed only at cmd_end
    cyc("R7", 1, 12, 0, 3, 6'h15, 0, 0);
    idle("R7", 2);
    cyc("R7", 1, 11, 0, 3, 0, 0, 0);
    cyc("R7", 0, 0, 0, 0, 0, 0, 1);
    // R9 / R12: requests during busy window
    cyc("R12", 1, 5, 0, 0, 0, 0, 0);
    cyc("R9", 1, 12, 1, 1, 6'h33, 0, 0);
    cyc("R9", 0, 0, 0, 0, 0, 0, 1);
    cyc("R9", 1, 10, 3, 0, 6'h07, 0, 0);
    cyc("R9", 1, 9, 3, 0, 0, 0, 0);
    idle("R7", S);
    cyc("R7", 1, 11, 0, 3, 0, 0, 0);
    cyc("R9", 1, 11, 1, 1, 0, 0, 0);
    cyc("R12", 1, 5, 0, 0, 0, 0, 0);
    // R5: wiper to register single transfer
    cyc("R5", 1, 14, 1, 2, 0, 0, 0);
    cyc("R5", 0, 0, 0, 0, 0, 0, 1);
    idle("R5", S + 1);
    cyc("R5", 1, 11, 1, 2, 0, 0, 0);
    // R6: global wiper to register transfer
    cyc("R6", 1, 8, 0, 0, 0, 0, 0);
    cyc("R6", 0, 0, 0, 0, 0, 0, 1);
    idle("R6", S + 1);
    for (int c = 0; c < 4; c++) cyc("R6", 1, 11, c, 0, 0, 0, 0);
    // R8: write protect blocks register changes, not wiper writes
    wp_n = 1'b0;
    cyc("R8", 1, 12, 2, 2, 6'h3C, 0, 0);
    cyc("R8", 0, 0, 0, 0, 0, 0, 1);
    cyc("R8", 1, 8, 0, 1, 0, 0, 0);
    cyc("R8", 0, 0, 0, 0, 0, 0, 1);
    cyc("R8", 1, 10, 2, 0, 6'h11, 0, 0);
    cyc("R8", 1, 11, 2, 2, 0, 0, 0);
    cyc("R8", 1, 11, 3, 1, 0, 0, 0);
    wp_n = 1'b1;
    // R1: reset recalls register 0 into each wiper
    do_reset();
    cyc("R1", 1, 11, 0, 3, 0, 0, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule